// File: doc/BRIEF.md
# Execution-Stage ALU with Condition Evaluator

This block is the arithmetic and logic core of a processor execution stage. On every clock it takes a left and a right operand, a 4-bit operation code, the carry flag stored by the processor, a multiply-step subtract request and a 4-bit condition selector. One clock later it presents the result word, the new value for the carry flag, a signed overflow flag, one selected branch/trap condition bit and an error flag for operation codes it does not know.

The operation code is decoded into one of five internal functions (add, subtract, and, or, xor) together with a carry-in policy and a carry-out policy. Each family of operations treats the carry in its own way. Signed and unsigned arithmetic consume the stored carry. The no-carry and long variants ignore it. Unsigned arithmetic returns the adder's carry out, while several classes return the stored flag unchanged. Subtraction is done on the same adder as left plus inverted right plus the inverted carry-in, so a stored carry acts as a borrow.

The condition selector picks one of seven base tests, or its complement. The tests cover zero, sign, less-or-equal, overflow, a bounds check and a two-bit tag check, plus constant false and true. The surrounding stage uses the bit for conditional branches and traps.

Top module: `alu_cond_unit`

## Requirements
- R1: While rstN is low, every output is 0. The outputs for the inputs presented at one rising clock edge appear right after that edge and stay until the next edge.
- R2: Operation codes 0 (signed add), 2 (unsigned add), 4 (no-carry add) and 6 (long add) produce left + right + cin. Here cin is the stored carry for codes 0 and 2 and 0 for codes 4 and 6.
- R3: Operation codes 1, 3, 5 and 7 (signed, unsigned, no-carry and long subtract), 11 (bounds check) and 13 (divide step) produce left + ~right + ~cin, truncated to 32 bits. Here cin is the stored carry for codes 1 and 3 and 0 otherwise.
- R4: Operation codes 8, 9 and 10 produce left AND right, left OR right and left XOR right.
- R5: Operation code 12 (multiply step) subtracts when mulSub is 1 and adds when mulSub is 0, with carry-in 0 in both cases.
- R6: After codes 0, 1, 6, 7, 12 and 13 the new carry flag is 0.
- R7: After codes 2 and 3 the new carry flag is the adder's carry out of the top bit.
- R8: After codes 4, 5, 8, 9, 10 and 11 the new carry flag equals the stored carry input.
- R9: Overflow is 1 when two things hold. The sign of left equals the sign of the effective right operand, which is the negated right for codes 1, 3, 5, 7 and 11 and right otherwise. The sign of the result also differs from the sign of left.
- R10: Condition codes 0 to 6 select, in order: result zero, result negative, result ≤ 0 (signed), overflow, bounds check, illegal tag, constant false.
- R11: Condition codes 8 to 15 return the complement of codes 0 to 7. Code 7 always gives 0 and code 15 always gives 1.
- R12: The bounds-check condition is 0 exactly when left is non-negative and the result is negative, and 1 otherwise.
- R13: The illegal-tag condition is 1 when bits 31 and 30 differ in left, in right or in the result.
- R14: Operation codes 14 and 15 raise opErr. They give result 0, overflow 0 and condition 0, and the carry flag is returned unchanged. For every other code opErr is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| leftOp | input | 32 | Left operand |
| rightOp | input | 32 | Right operand |
| opCode | input | 4 | Operation code (0..13 defined) |
| mulSub | input | 1 | Multiply step: 1 subtracts, 0 adds |
| carryIn | input | 1 | Stored carry flag |
| condSel | input | 4 | Condition selector |
| resultOut | output | 32 | Registered result word |
| carryOut | output | 1 | Registered new carry flag |
| ovfOut | output | 1 | Registered signed overflow |
| condOut | output | 1 | Registered selected condition |
| opErr | output | 1 | Registered unknown-operation flag |

## Verification
All five results are due in the cycle after the edge that samples their inputs. Exactly one register lies between the ports, so nothing arrives earlier or later. The bench changes inputs on the falling edge and compares every output on the following falling edge, against a behavioural model evaluated from the inputs it just applied. Directed vectors cover the carry classes, the sign boundaries for overflow and the bounds check, and every condition code. A long run of pseudo-random vectors then covers the remaining combinations.

// File: rtl/alu_cond_pkg.sv
package alu_cond_pkg;

  localparam logic [3:0] OP_SADD  = 4'd0;
  localparam logic [3:0] OP_SSUB  = 4'd1;
  localparam logic [3:0] OP_UADD  = 4'd2;
  localparam logic [3:0] OP_USUB  = 4'd3;
  localparam logic [3:0] OP_VADD  = 4'd4;
  localparam logic [3:0] OP_VSUB  = 4'd5;
  localparam logic [3:0] OP_LADD  = 4'd6;
  localparam logic [3:0] OP_LSUB  = 4'd7;
  localparam logic [3:0] OP_AND   = 4'd8;
  localparam logic [3:0] OP_OR    = 4'd9;
  localparam logic [3:0] OP_XOR   = 4'd10;
  localparam logic [3:0] OP_BND   = 4'd11;
  localparam logic [3:0] OP_MSTEP = 4'd12;
  localparam logic [3:0] OP_DSTEP = 4'd13;

  localparam logic [2:0] CB_ZERO  = 3'd0;
  localparam logic [2:0] CB_NEG   = 3'd1;
  localparam logic [2:0] CB_LEZ   = 3'd2;
  localparam logic [2:0] CB_OVF   = 3'd3;
  localparam logic [2:0] CB_BOUND = 3'd4;
  localparam logic [2:0] CB_TAG   = 3'd5;
  localparam logic [2:0] CB_FALSE = 3'd6;
  localparam logic [2:0] CB_RSVD  = 3'd7;

  typedef enum logic [2:0] {FN_ADD, FN_SUB, FN_AND, FN_OR, FN_XOR} aluFn_e;
  typedef enum logic [1:0] {CO_ZERO, CO_ADDER, CO_KEEP} coutMode_e;

  typedef struct packed {
    aluFn_e    fn;
    logic      takeCarry;
    coutMode_e coutMode;
    logic      negRight;
    logic      err;
  } aluCtl_t;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_cond_pkg::*;
(
  input  logic [3:0] opCode,
  input  logic       mulSub,
  output aluCtl_t    ctl
);

  always_comb begin
    ctl.fn        = FN_ADD;
    ctl.takeCarry = 1'b0;
    ctl.coutMode  = CO_KEEP;
    ctl.negRight  = 1'b0;
    ctl.err       = 1'b0;
    case (opCode)
      OP_SADD:  begin ctl.takeCarry = 1'b1; ctl.coutMode = CO_ZERO; end
      OP_SSUB:  begin ctl.fn = FN_SUB; ctl.takeCarry = 1'b1; ctl.coutMode = CO_ZERO; ctl.negRight = 1'b1; end
      OP_UADD:  begin ctl.takeCarry = 1'b1; ctl.coutMode = CO_ADDER; end
      OP_USUB:  begin ctl.fn = FN_SUB; ctl.takeCarry = 1'b1; ctl.coutMode = CO_ADDER; ctl.negRight = 1'b1; end
      OP_VADD:  begin ctl.coutMode = CO_KEEP; end
      OP_VSUB:  begin ctl.fn = FN_SUB; ctl.negRight = 1'b1; end
      OP_LADD:  begin ctl.coutMode = CO_ZERO; end
      OP_LSUB:  begin ctl.fn = FN_SUB; ctl.coutMode = CO_ZERO; ctl.negRight = 1'b1; end
      OP_AND:   begin ctl.fn = FN_AND; end
      OP_OR:    begin ctl.fn = FN_OR; end
      OP_XOR:   begin ctl.fn = FN_XOR; end
      OP_BND:   begin ctl.fn = FN_SUB; ctl.negRight = 1'b1; end
      OP_MSTEP: begin ctl.fn = mulSub ? FN_SUB : FN_ADD; ctl.coutMode = CO_ZERO; end
      OP_DSTEP: begin ctl.fn = FN_SUB; ctl.coutMode = CO_ZERO; end
      default:  begin ctl.err = 1'b1; end
    endcase
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_cond_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  aluCtl_t          ctl,
  input  logic [WIDTH-1:0] leftOp,
  input  logic [WIDTH-1:0] rightOp,
  input  logic             carryIn,
  input  logic [3:0]       condSel,
  output logic [WIDTH-1:0] resultQ,
  output logic             carryQ,
  output logic             ovfQ,
  output logic             condQ,
  output logic             errQ
);

  localparam int MSB = WIDTH - 1;
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  logic             isSub;
  logic             cinEff;
  logic             adderCin;
  logic [WIDTH-1:0] addRight;
  logic [WIDTH:0]   addSum;
  logic             rawCarry;
  logic [WIDTH-1:0] resultD;
  logic             carryD;
  logic [WIDTH-1:0] ovfRight;
  logic             ovfD;
  logic [7:0]       condBase;
  logic             condD;
  logic             boundFail;
  logic             tagBad;
  logic             resZero;

  // one adder serves add and subtract; subtract inverts right and carry-in
  assign isSub    = (ctl.fn == FN_SUB);
  assign cinEff   = ctl.takeCarry & carryIn;
  assign adderCin = isSub ? ~cinEff : cinEff;
  assign addRight = isSub ? ~rightOp : rightOp;
  assign addSum   = {1'b0, leftOp} + {1'b0, addRight} + {{WIDTH{1'b0}}, adderCin};

  always_comb begin
    rawCarry = 1'b0;
    case (ctl.fn)
      FN_ADD, FN_SUB: begin resultD = addSum[MSB:0]; rawCarry = addSum[WIDTH]; end
      FN_AND:         resultD = leftOp & rightOp;
      FN_OR:          resultD = leftOp | rightOp;
      FN_XOR:         resultD = leftOp ^ rightOp;
      default:        resultD = '0;
    endcase
    if (ctl.err) resultD = '0;
  end

  always_comb begin
    case (ctl.coutMode)
      CO_ZERO:  carryD = 1'b0;
      CO_ADDER: carryD = rawCarry;
      default:  carryD = carryIn;
    endcase
  end

  assign ovfRight = ctl.negRight ? (~rightOp + ONE) : rightOp;
  assign ovfD     = ~ctl.err & (leftOp[MSB] == ovfRight[MSB]) & (resultD[MSB] != leftOp[MSB]);

  assign resZero   = (resultD == '0);
  assign boundFail = ~leftOp[MSB] & resultD[MSB];
  assign tagBad    = (leftOp[MSB] ^ leftOp[MSB-1]) | (rightOp[MSB] ^ rightOp[MSB-1])
                   | (resultD[MSB] ^ resultD[MSB-1]);

  always_comb begin
    condBase           = '0;
    condBase[CB_ZERO]  = resZero;
    condBase[CB_NEG]   = resultD[MSB];
    condBase[CB_LEZ]   = resZero | resultD[MSB];
    condBase[CB_OVF]   = ovfD;
    condBase[CB_BOUND] = ~boundFail;
    condBase[CB_TAG]   = tagBad;
    condBase[CB_FALSE] = 1'b0;
    condBase[CB_RSVD]  = 1'b0;
    condD = ctl.err ? 1'b0 : (condSel[3] ^ condBase[condSel[2:0]]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultQ <= '0;
      carryQ  <= 1'b0;
      ovfQ    <= 1'b0;
      condQ   <= 1'b0;
      errQ    <= 1'b0;
    end else begin
      resultQ <= resultD;
      carryQ  <= carryD;
      ovfQ    <= ovfD;
      condQ   <= condD;
      errQ    <= ctl.err;
    end
  end

  a_r6_carry_cleared: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.coutMode == CO_ZERO) |=> !carryQ);

  a_r8_carry_kept: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.coutMode == CO_KEEP) |=> (carryQ == $past(carryIn)));

  a_r14_error_zero: assert property (@(posedge clk) disable iff (!rstN)
    ctl.err |=> (errQ && resultQ == '0 && !ovfQ && !condQ));

  a_r11_always_true: assert property (@(posedge clk) disable iff (!rstN)
    (condSel == 4'hF && !ctl.err) |=> condQ);

  a_r11_reserved_false: assert property (@(posedge clk) disable iff (!rstN)
    (condSel == 4'h7) |=> !condQ);

endmodule

// File: rtl/alu_cond_unit.sv
module alu_cond_unit
  import alu_cond_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] leftOp,
  input  logic [WIDTH-1:0] rightOp,
  input  logic [3:0]       opCode,
  input  logic             mulSub,
  input  logic             carryIn,
  input  logic [3:0]       condSel,
  output logic [WIDTH-1:0] resultOut,
  output logic             carryOut,
  output logic             ovfOut,
  output logic             condOut,
  output logic             opErr
);

  aluCtl_t ctl;

  alu_ctrl u_ctrl (
    .opCode (opCode),
    .mulSub (mulSub),
    .ctl    (ctl)
  );

  alu_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .leftOp  (leftOp),
    .rightOp (rightOp),
    .carryIn (carryIn),
    .condSel (condSel),
    .resultQ (resultOut),
    .carryQ  (carryOut),
    .ovfQ    (ovfOut),
    .condQ   (condOut),
    .errQ    (opErr)
  );

endmodule

// File: tb/alu_cond_unit_tb.sv
module alu_cond_unit_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] leftOp = '0;
  logic [31:0] rightOp = '0;
  logic [3:0]  opCode = '0;
  logic        mulSub = 1'b0;
  logic        carryIn = 1'b0;
  logic [3:0]  condSel = '0;
  logic [31:0] resultOut;
  logic        carryOut, ovfOut, condOut, opErr;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_cond_unit u_dut (
    .clk(clk), .rstN(rstN), .leftOp(leftOp), .rightOp(rightOp), .opCode(opCode),
    .mulSub(mulSub), .carryIn(carryIn), .condSel(condSel), .resultOut(resultOut),
    .carryOut(carryOut), .ovfOut(ovfOut), .condOut(condOut), .opErr(opErr)
  );

  // behavioural reference model
  logic [31:0] eRes;
  logic        eCarry, eOvf, eCond, eErr;

  function automatic string resTag(input int op);
    if (op >= 14) return "R14";
    if (op == 12) return "R5";
    if (op >= 8 && op <= 10) return "R4";
    if (op == 0 || op == 2 || op == 4 || op == 6) return "R2";
    return "R3";
  endfunction

  function automatic string carryTag(input int op);
    if (op >= 14) return "R14";
    if (op == 2 || op == 3) return "R7";
    if (op == 0 || op == 1 || op == 6 || op == 7 || op == 12 || op == 13) return "R6";
    return "R8";
  endfunction

  function automatic string condTag(input int cs);
    if (cs == 4 || cs == 12) return "R12";
    if (cs == 5 || cs == 13) return "R13";
    if (cs >= 7) return "R11";
    return "R10";
  endfunction

  task automatic model(input logic [31:0] l, input logic [31:0] r, input int op,
                       input logic ms, input logic cin, input int cs);
    bit doSub, useCin, negR;
    logic [32:0] s;
    logic [31:0] effR;
    bit base;
    int c;
    eErr = (op >= 14);
    doSub = (op == 1 || op == 3 || op == 5 || op == 7 || op == 11 || op == 13 || (op == 12 && ms));
    useCin = (op <= 3) ? cin : 1'b0;
    negR = (op == 1 || op == 3 || op == 5 || op == 7 || op == 11);
    if (doSub) s = {1'b0, l} + {1'b0, ~r} + (useCin ? 33'd0 : 33'd1);
    else       s = {1'b0, l} + {1'b0, r} + (useCin ? 33'd1 : 33'd0);
    if (op == 8)       eRes = l & r;
    else if (op == 9)  eRes = l | r;
    else if (op == 10) eRes = l ^ r;
    else if (eErr)     eRes = 32'd0;
    else               eRes = s[31:0];
    if (op == 2 || op == 3) eCarry = s[32];
    else if (op == 0 || op == 1 || op == 6 || op == 7 || op == 12 || op == 13) eCarry = 1'b0;
    else eCarry = cin;
    effR = negR ? (32'd0 - r) : r;
    eOvf = !eErr && (l[31] == effR[31]) && (eRes[31] != l[31]);
    c = cs % 8;
    case (c)
      0: base = (eRes == 0);
      1: base = eRes[31];
      2: base = (eRes == 0) || eRes[31];
      3: base = eOvf;
      4: base = !(!l[31] && eRes[31]);
      5: base = (l[31] != l[30]) || (r[31] != r[30]) || (eRes[31] != eRes[30]);
      default: base = 1'b0;
    endcase
    eCond = eErr ? 1'b0 : ((cs >= 8) ? !base : base);
  endtask

  task automatic step(input logic [31:0] l, input logic [31:0] r, input int op,
                      input logic ms, input logic cin, input int cs);
    leftOp = l; rightOp = r; opCode = 4'(op); mulSub = ms; carryIn = cin; condSel = 4'(cs);
    model(l, r, op, ms, cin, cs);
    @(negedge clk);
    vectors++;
    if (resultOut !== eRes) begin
      fails++; $display("FAIL %s op=%0d result got %h exp %h", resTag(op), op, resultOut, eRes);
    end
    if (carryOut !== eCarry) begin
      fails++; $display("FAIL %s op=%0d carry got %b exp %b", carryTag(op), op, carryOut, eCarry);
    end
    if (ovfOut !== eOvf) begin
      fails++; $display("FAIL R9 op=%0d overflow got %b exp %b", op, ovfOut, eOvf);
    end
    if (condOut !== eCond) begin
      fails++; $display("FAIL %s op=%0d sel=%0d cond got %b exp %b", condTag(cs), op, cs, condOut, eCond);
    end
    if (opErr !== eErr) begin
      fails++; $display("FAIL R14 op=%0d err got %b exp %b", op, opErr, eErr);
    end
  endtask

  initial begin
    repeat (2) @(negedge clk);
    vectors++;
    if (resultOut !== 32'd0 || carryOut || ovfOut || condOut || opErr) begin
      fails++; $display("FAIL R1 reset outputs got %h/%b%b%b%b exp 0", resultOut, carryOut, ovfOut, condOut, opErr);
    end
    rstN = 1'b1;
    // R2 adds with and without stored carry
    step(32'd5, 32'd7, 0, 0, 1, 0);
    step(32'hFFFF_FFFF, 32'd1, 2, 0, 1, 0);
    step(32'd5, 32'd7, 4, 0, 1, 8);
    step(32'h7FFF_FFFF, 32'd1, 6, 0, 1, 3);
    // R3 subtracts, borrow via stored carry
    step(32'd10, 32'd3, 3, 0, 1, 1);
    step(32'd3, 32'd10, 3, 0, 0, 1);
    step(32'h8000_0000, 32'd1, 1, 0, 0, 3);
    step(32'd9, 32'd9, 5, 0, 1, 0);
    step(32'd9, 32'd2, 7, 0, 1, 2);
    step(32'd9, 32'd2, 13, 0, 1, 10);
    // R4 logic and kept carry R8
    step(32'hF0F0_1234, 32'h0FF0_FF00, 8, 0, 1, 0);
    step(32'hF0F0_1234, 32'h0FF0_FF00, 9, 0, 0, 1);
    step(32'hF0F0_1234, 32'h0FF0_FF00, 10, 0, 1, 5);
    // R5 multiply step both ways
    step(32'd100, 32'd30, 12, 1, 1, 0);
    step(32'd100, 32'd30, 12, 0, 1, 0);
    // R12 bounds check: pass, fail, negative arg
    step(32'd3, 32'd10, 11, 0, 1, 4);
    step(32'd12, 32'd10, 11, 0, 0, 4);
    step(32'hFFFF_FFF0, 32'd10, 11, 0, 0, 12);
    // R13 tag checks
    step(32'h4000_0000, 32'd0, 9, 0, 0, 5);
    step(32'h0000_0001, 32'h0000_0002, 9, 0, 0, 13);
    // R11 reserved and true, all selectors on one vector
    for (int cs = 0; cs < 16; cs++) step(32'h7FFF_FFFF, 32'hFFFF_FFFF, 1, 0, 0, cs);
    // R14 unknown codes
    step(32'd1, 32'd2, 14, 0, 1, 15);
    step(32'd1, 32'd2, 15, 0, 0, 0);
    // pseudo-random sweep
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a, b;
      a = $urandom;
      b = $urandom;
      if (i % 7 == 0) b = a;
      step(a, b, int'($urandom % 16), 1'($urandom), 1'($urandom), int'($urandom % 16));
    end
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule